// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

A purely combinational multiplier for two's-complement integers. Two 32-bit operands enter and a 64-bit exact product leaves, with no clock and no state. The multiplier operand is recoded into signed radix-4 digits. Each digit is read from a 3-bit window of that operand, and adjacent windows share one bit. Each digit picks zero, plus or minus one times the multiplicand, or plus or minus two times the multiplicand, and places the result at the digit's weight.

The sixteen resulting partial products are sign-extended to the full product width. A balanced binary tree of ripple-carry adders, four levels deep, then sums them. Both operand widths are parameters. The multiplier width must be even. The tree is padded with zero leaves when the digit count is not a power of two.

Top module: `booth_mul`

## Requirements
- R1: `product` equals the exact signed product of `op_a` and `op_b`, both read as two's complement, over the full 64-bit width.
- R2: When either operand is zero, `product` is zero.
- R3: When `op_a` is 1, `product` is `op_b` sign-extended to 64 bits. When `op_b` is 1, `product` is `op_a` sign-extended to 64 bits.
- R4: When both operands are nonzero, bit 63 of `product` equals the XOR of bit 31 of `op_a` and bit 31 of `op_b`.
- R5: Extreme operands are exact:
  - -2^31 times -2^31 gives 0x4000_0000_0000_0000.
  - -2^31 times 1 gives 0xFFFF_FFFF_8000_0000.
  - -2^31 times -1 gives 0x0000_0000_8000_0000.
- R6: Digit i of `op_b` is read from the window {b[2i+1], b[2i], b[2i-1]}, with b[-1] taken as 0. The window maps to a digit as follows:
  - 000 and 111 give 0.
  - 001 and 010 give +1.
  - 011 gives +2.
  - 100 gives -2.
  - 101 and 110 give -1.
  - The digit multiplies `op_a` at weight 4^i.
  - Multiplier patterns that hold every digit value (all ones, alternating bits, the largest positive value, a single set bit at the top) yield exact products.
- R7: The block holds no state. `product` follows a change of either operand within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Multiplicand, two's complement |
| op_b | input | 32 | Multiplier, two's complement, Booth-recoded |
| product | output | 64 | Signed product |

## Verification
The bench drives several kinds of multiplier patterns:
- Sparse multipliers with one or two set bits isolate a single digit position and its sign.
- Dense patterns drive every window to the same code: all ones gives digit 0 everywhere except the lowest, alternating bits give a chain of -1 digits, and the largest positive value mixes +2 and 0 digits.
- The most negative operand against itself, against 1 and against -1 exposes any sign-extension or carry loss at the top of the tree.
- Random operand pairs in all four sign quadrants catch misrouted tree nodes that the structured patterns would leave unnoticed.

An operand change applied mid-period is checked before the next edge. This separates a combinational path from an accidental register.

// File: rtl/booth_pkg.sv
package booth_pkg;
   // one signed radix-4 digit: magnitude select plus sign
   typedef struct packed {
      logic neg;   // subtract the selected multiple
      logic one;   // magnitude 1
      logic two;   // magnitude 2
   } bdigit_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic [2:0] win,   // {b[2i+1], b[2i], b[2i-1]}
   output bdigit_t    dig
);
   always_comb begin
      dig.one = win[1] ^ win[0];
      dig.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
      dig.neg = win[2] & ~(win[1] & win[0]);
   end
endmodule

// File: rtl/booth_rca.sv
module booth_rca #(
   parameter int W = 64
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] s
);
   logic [W-1:0] c;
   assign c[0] = cin;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign s[k] = x[k] ^ y[k] ^ c[k];
      if (k < W-1) begin : g_carry
         assign c[k+1] = (x[k] & y[k]) | (c[k] & (x[k] ^ y[k]));
      end
   end
endmodule

// File: rtl/booth_pp_sel.sv
module booth_pp_sel
   import booth_pkg::*;
#(
   parameter int A_W = 32,
   parameter int P_W = 64,
   parameter int IDX = 0
) (
   input  logic [A_W-1:0] a,
   input  bdigit_t        dig,
   output logic [P_W-1:0] pp
);
   localparam int SHIFT = 2*IDX;

   logic [P_W-1:0] a_ext, mag, flip, twos;
   logic [P_W-1:0] c;

   assign a_ext = {{(P_W-A_W){a[A_W-1]}}, a};

   always_comb begin
      if (dig.one)      mag = a_ext;
      else if (dig.two) mag = a_ext << 1;
      else              mag = '0;
   end

   assign flip = dig.neg ? ~mag : mag;

   // increment chain completes the two's-complement negation
   assign c[0] = dig.neg;
   for (genvar k = 0; k < P_W; k++) begin : g_inc
      assign twos[k] = flip[k] ^ c[k];
      if (k < P_W-1) begin : g_c
         assign c[k+1] = flip[k] & c[k];
      end
   end

   assign pp = twos << SHIFT;
endmodule

// File: rtl/booth_mul.sv
module booth_mul
   import booth_pkg::*;
#(
   parameter int A_W = 32,
   parameter int B_W = 32
) (
   input  logic [A_W-1:0]     op_a,
   input  logic [B_W-1:0]     op_b,
   output logic [A_W+B_W-1:0] product
);
   localparam int P_W    = A_W + B_W;
   localparam int NPP    = B_W / 2;
   localparam int LEVELS = (NPP > 1) ? $clog2(NPP) : 0;
   localparam int NLEAF  = 1 << LEVELS;
   localparam int NNODE  = 2*NLEAF - 1;

   if (A_W < 2) begin : g_bad_a
      $error("booth_mul: A_W must be at least 2");
   end
   if ((B_W < 2) || (B_W % 2 != 0)) begin : g_bad_b
      $error("booth_mul: B_W must be even and at least 2");
   end

   logic [B_W:0]   b_ext;
   bdigit_t        dig  [NPP];
   logic [P_W-1:0] pp   [NPP];
   logic [P_W-1:0] node [NNODE];

   assign b_ext = {op_b, 1'b0};

   for (genvar i = 0; i < NPP; i++) begin : g_pp
      booth_recoder u_rec (
         .win (b_ext[2*i+2 -: 3]),
         .dig (dig[i])
      );
      booth_pp_sel #(.A_W(A_W), .P_W(P_W), .IDX(i)) u_sel (
         .a   (op_a),
         .dig (dig[i]),
         .pp  (pp[i])
      );
   end

   // heap-ordered tree: leaves at NLEAF-1.., node k sums 2k+1 and 2k+2
   for (genvar l = 0; l < NLEAF; l++) begin : g_leaf
      if (l < NPP) begin : g_used
         assign node[NLEAF-1+l] = pp[l];
      end else begin : g_pad
         assign node[NLEAF-1+l] = '0;
      end
   end

   for (genvar k = 0; k < NLEAF-1; k++) begin : g_sum
      booth_rca #(.W(P_W)) u_add (
         .x   (node[2*k+1]),
         .y   (node[2*k+2]),
         .cin (1'b0),
         .s   (node[k])
      );
   end

   assign product = node[0];
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
   parameter int A_W = 32,
   parameter int B_W = 32
) (
   input logic [A_W-1:0]     op_a,
   input logic [B_W-1:0]     op_b,
   input logic [A_W+B_W-1:0] product
);
   localparam int P_W = A_W + B_W;
   localparam logic [A_W-1:0] A_MIN = {1'b1, {(A_W-1){1'b0}}};
   localparam logic [B_W-1:0] B_MIN = {1'b1, {(B_W-1){1'b0}}};
   localparam logic [P_W-1:0] MINMIN = {2'b01, {(P_W-2){1'b0}}};

   always_comb begin
      if (op_a == '0) AST_ZERO_A: assert (product == '0); // R2
      if (op_b == '0) AST_ZERO_B: assert (product == '0); // R2
      if (op_a == A_W'(1)) AST_UNIT_A: assert ($signed(product) == $signed(op_b)); // R3
      if (op_b == B_W'(1)) AST_UNIT_B: assert ($signed(product) == $signed(op_a)); // R3
      if (op_a != '0 && op_b != '0)
         AST_SIGN: assert (product[P_W-1] == (op_a[A_W-1] ^ op_b[B_W-1])); // R4
      if (op_a == A_MIN && op_b == B_MIN) AST_MINMIN: assert (product == MINMIN); // R5
   end
endmodule

bind booth_mul booth_mul_chk #(.A_W(A_W), .B_W(B_W)) chk_i (
   .op_a    (op_a),
   .op_b    (op_b),
   .product (product)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a, b;
   logic [63:0] p;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   booth_mul dut_i (.op_a(a), .op_b(b), .product(p));

   function automatic logic [63:0] model(input logic [31:0] x, input logic [31:0] y);
      longint sx, sy;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      return 64'(sx * sy);
   endfunction

   task automatic check(input string req, input logic [63:0] exp);
      total++;
      if (p !== exp) begin
         bad++;
         $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, p, exp);
      end
   endtask

   task automatic apply(input string req, input logic [31:0] x, input logic [31:0] y);
      @(posedge clk);
      #1 a = x; b = y;
      @(negedge clk);
      check(req, model(x, y));
   endtask

   initial begin
      a = '0; b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2 reset", 64'd0);
      rst_n = 1'b1;

      apply("R1 small", 32'd7, 32'd9);
      apply("R1 neg*pos", 32'hFFFF_FFFD, 32'd11);
      apply("R2 zero a", 32'd0, 32'h1234_5678);
      apply("R2 zero b", 32'h8765_4321, 32'd0);
      apply("R3 unit a", 32'd1, 32'h8000_0001);
      apply("R3 unit b", 32'hF000_000F, 32'd1);
      apply("R4 sign", 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      apply("R5 min*min", 32'h8000_0000, 32'h8000_0000);
      apply("R5 min*one", 32'h8000_0000, 32'd1);
      apply("R5 min*m1", 32'h8000_0000, 32'hFFFF_FFFF);
      apply("R6 all ones", 32'h1357_9BDF, 32'hFFFF_FFFF);
      apply("R6 alt AA", 32'h0F0F_0F0F, 32'hAAAA_AAAA);
      apply("R6 alt 55", 32'hF0F0_F0F0, 32'h5555_5555);
      apply("R6 max pos", 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      apply("R6 top bit", 32'h0000_0003, 32'h8000_0000);
      for (int i = 0; i < 32; i++)
         apply("R6 single bit", 32'hDEAD_BEEF, 32'd1 << i);

      // R7: change operands mid-period, check before the next edge
      @(posedge clk);
      #1 a = 32'd1000; b = 32'hFFFF_FC18;
      #1 check("R7 comb", model(32'd1000, 32'hFFFF_FC18));
      a = 32'h0001_0000;
      #0.5 check("R7 comb follow", model(32'h0001_0000, 32'hFFFF_FC18));

      for (int i = 0; i < 400; i++)
         apply("R1 random", $urandom, $urandom);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule